// File: doc/BRIEF.md
# Timer Clock-Select Prescaler

This block turns a 3-bit clock-select code into a count-enable strobe for a timer that runs in the system clock domain. The code picks one of several sources. It can stop the timer, enable it on every system clock, enable it once every 8, 64, 256 or 1024 system clocks, or enable it on the falling or rising edges of an external clock pin.

The divided ratios come from a free-running 10-bit counter. Each divider fires in the one cycle where the counter's low bits are all ones. A prescaler-clear strobe zeroes that counter so that the next divided tick lands at a known distance from the strobe. The external pin passes through a two-flop synchronizer and an edge detector, so the block produces at most one strobe per system clock.

The select code is registered. A new code therefore governs the strobe from the cycle after the edge that samples it. The edge detector and the counter keep running whatever code is selected, so switching codes never creates an extra strobe.

Top module: `tclk_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release (with code 000 held), `cnt_en_o` is low.
- R2: With code 000 selected, `cnt_en_o` stays low whatever the external pin and the clear strobe do.
- R3: With code 001 selected, `cnt_en_o` is high in every cycle.
- R4: Codes 010, 011, 100 and 101 divide by D = 8, 64, 256 and 1024. In cycle i after an edge that samples `pre_clr_i` high (i = 0 is the cycle right after that edge), `cnt_en_o` is high exactly when i mod D equals D-1.
- R5: The prescaler counter advances in every cycle whatever code is selected. A divided code picked some cycles after a clear follows the same phase as in R4.
- R6: With code 111, one strobe appears for each low-to-high change of `ext_clk_i`. If the pin's new level is first sampled at edge n, the strobe is high in the cycle after edge n+1 and in no other cycle.
- R7: With code 110, one strobe appears for each high-to-low change of `ext_clk_i`, with the same timing as R6. Rising changes produce no strobe.
- R8: A code presented at a clock edge governs `cnt_en_o` from the cycle after that edge. Changing the code (for example between 111 and 110, or from 000 to 111 with the pin steady) produces no strobe that the new code alone would not produce.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 3 | Clock-select code |
| ext_clk_i | input | 1 | External clock pin (asynchronous) |
| pre_clr_i | input | 1 | Prescaler counter clear strobe |
| cnt_en_o | output | 1 | Single-cycle timer count enable |

## Verification
The bench sweeps every divided code across two full periods after a clear. A tap that decodes the wrong bits, or a clear that lands one cycle off, therefore shows up as a strobe in the wrong cycle. A separate run clears the counter while the timer is stopped and only later selects a divider. A design that restarted the counter on a code change would put its first strobe late.

Both external-edge modes get a pseudo-random pin pattern that includes one-cycle pulses. A detector with the wrong latency, the wrong polarity, or a pulse longer than one cycle makes the strobe disagree with the pin history. The bench also switches codes while the pin is held steady. A detector that ran only while selected would then report a stale level as a fresh edge.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

  typedef enum logic [2:0] {
    CS_STOP     = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } clk_sel_e;

  localparam int NUM_TAPS = 4;

  // log2 of the division ratio for each prescaler tap, in code order.
  function automatic int tap_shift(int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // Tap index used by a divided select code (codes 010..101).
  function automatic int code_to_tap(clk_sel_e code);
    return int'(code) - int'(CS_DIV8);
  endfunction

endpackage

// File: rtl/tclk_prescaler.sv
module tclk_prescaler
  import tclk_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tap_o
);

  logic [PRE_W-1:0] cnt_q;

  // Free-running; the clear only resets the phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int SH = tap_shift(g);
    if (SH > PRE_W) begin : g_bad
      initial $error("prescaler width below tap %0d", g);
      assign tap_o[g] = 1'b0;
    end else begin : g_ok
      assign tap_o[g] = &cnt_q[SH-1:0];
    end
  end

  AST_CLR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R4

  for (genvar g = 1; g < NUM_TAPS; g++) begin : g_nest
    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o[g] |-> tap_o[g-1]); // R4
  end

endmodule

// File: rtl/tclk_edge_sync.sv
module tclk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o =  sync_q[LAST] & ~prev_q;
  assign fall_o = ~sync_q[LAST] &  prev_q;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o)); // R7

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R7

endmodule

// File: rtl/tclk_select.sv
module tclk_select
  import tclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                en_o
);

  clk_sel_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= CS_STOP;
    else        sel_q <= clk_sel_e'(sel_i);
  end

  always_comb begin
    unique case (sel_q)
      CS_STOP:     en_o = 1'b0;
      CS_DIV1:     en_o = 1'b1;
      CS_DIV8,
      CS_DIV64,
      CS_DIV256,
      CS_DIV1024:  en_o = tap_i[code_to_tap(sel_q)];
      CS_EXT_FALL: en_o = fall_i;
      CS_EXT_RISE: en_o = rise_i;
      default:     en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tclk_gen.sv
module tclk_gen
  import tclk_pkg::*;
#(
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel_i,
  input  logic       ext_clk_i,
  input  logic       pre_clr_i,
  output logic       cnt_en_o
);

  logic [NUM_TAPS-1:0] tap_w;
  logic                ext_rise_w;
  logic                ext_fall_w;

  tclk_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (pre_clr_i),
    .tap_o (tap_w)
  );

  tclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_clk_i),
    .rise_o (ext_rise_w),
    .fall_o (ext_fall_w)
  );

  tclk_select u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (clk_sel_i),
    .tap_i  (tap_w),
    .rise_i (ext_rise_w),
    .fall_i (ext_fall_w),
    .en_o   (cnt_en_o)
  );

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == CS_STOP) |=> !cnt_en_o); // R2

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == CS_DIV1) |=> cnt_en_o); // R3

  AST_RISE_MODE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == CS_EXT_RISE) |=> (cnt_en_o == ext_rise_w)); // R8

  AST_FALL_MODE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == CS_EXT_FALL) |=> (cnt_en_o == ext_fall_w)); // R8

endmodule

// File: tb/tb_tclk_gen.sv
`timescale 1ns/1ps
module tb_tclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel_i = 3'b000;
  logic       ext_clk_i = 1'b0;
  logic       pre_clr_i = 1'b0;
  logic       cnt_en_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Pin history: values driven at the last three negedges.
  logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tclk_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel_i (clk_sel_i),
    .ext_clk_i (ext_clk_i),
    .pre_clr_i (pre_clr_i),
    .cnt_en_o  (cnt_en_o)
  );

  task automatic check(input logic got, input logic exp, input string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: cnt_en_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive_pin(input logic v);
    ext_clk_i = v;
    h3 = h2; h2 = h1; h1 = v;
  endtask

  // One negedge: returns after sampling point; caller drives afterwards.
  task automatic step();
    @(negedge clk);
  endtask

  // Divider sweep: clear with code set, then 2*D samples.
  task automatic div_sweep(input logic [2:0] code, input int d);
    step();
    clk_sel_i = code;
    pre_clr_i = 1'b1;
    for (int i = 0; i < 2 * d; i++) begin
      step();
      check(cnt_en_o, (i % d) == d - 1, "R4");
      pre_clr_i = 1'b0;
    end
  endtask

  // External edge run with pseudo-random pin, pulses expected from history.
  task automatic ext_run(input logic [2:0] code, input int n);
    step();
    clk_sel_i = code;
    for (int k = 0; k < 4; k++) begin step(); drive_pin(ext_clk_i); end
    for (int i = 0; i < n; i++) begin
      step();
      if (code == 3'b111) check(cnt_en_o, h2 & ~h3, "R6");
      else                check(cnt_en_o, ~h2 & h3, "R7");
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive_pin(lfsr[0] ? ~ext_clk_i : ext_clk_i);
    end
  endtask

  initial begin
    // R1: reset
    repeat (3) begin step(); check(cnt_en_o, 1'b0, "R1"); end
    rst_n = 1'b1;
    step(); check(cnt_en_o, 1'b0, "R1");

    // R2: stopped, with pin toggling and clear strobes
    for (int i = 0; i < 64; i++) begin
      step();
      check(cnt_en_o, 1'b0, "R2");
      drive_pin(i[1]);
      pre_clr_i = i[2];
    end
    pre_clr_i = 1'b0;
    drive_pin(1'b0);

    // R3: full rate
    step(); clk_sel_i = 3'b001;
    for (int i = 0; i < 40; i++) begin step(); check(cnt_en_o, 1'b1, "R3"); end

    // R8: 001 -> 000 takes effect in the cycle after the sampling edge
    clk_sel_i = 3'b000;
    step(); check(cnt_en_o, 1'b0, "R8");

    // R4: every divided code
    div_sweep(3'b010, 8);
    div_sweep(3'b011, 64);
    div_sweep(3'b100, 256);
    div_sweep(3'b101, 1024);

    // R5: clear while stopped, select divider later; phase kept
    step();
    clk_sel_i = 3'b000;
    pre_clr_i = 1'b1;
    for (int i = 0; i < 48; i++) begin
      step();
      pre_clr_i = 1'b0;
      if (i < 6) check(cnt_en_o, 1'b0, "R5");
      else       check(cnt_en_o, (i % 8) == 7, "R5");
      if (i == 5) clk_sel_i = 3'b010;
    end

    // R6 / R7: external edges
    ext_run(3'b111, 400);
    ext_run(3'b110, 400);

    // R8: code switches with pin steady give no pulse
    step(); drive_pin(1'b1); clk_sel_i = 3'b000;
    for (int i = 0; i < 5; i++) begin step(); drive_pin(1'b1); end
    clk_sel_i = 3'b111;
    for (int i = 0; i < 5; i++) begin step(); check(cnt_en_o, 1'b0, "R8"); end
    clk_sel_i = 3'b110;
    for (int i = 0; i < 5; i++) begin step(); check(cnt_en_o, 1'b0, "R8"); end
    // then a real falling edge still counts once, two samples later
    drive_pin(1'b0);
    step(); check(cnt_en_o, 1'b0, "R8");
    step(); check(cnt_en_o, 1'b1, "R8");
    step(); check(cnt_en_o, 1'b0, "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule